// File: doc/BRIEF.md
# Priority Ternary Match Memory

This block is a lookup table that is searched by content rather than by address. It holds 128 rules. Each rule has a 15-bit pattern, a 15-bit per-bit don't-care mask and an 8-bit control word. A search presents one 15-bit key. Every rule is compared against the key in parallel. The block then returns the highest-numbered rule that matched, together with that rule's control word. A separate write port loads rules. The block gives the control word no meaning; a downstream sequencer acts on it.

Two rule slots are fixed. Slot 0 can never match, so a search never returns zero. Slot 1 always matches, so a key that hits nothing else returns 1 with a fixed default control word. Because of these two slots, every search yields a usable answer.

The result side is a two-state machine. In `S_IDLE` the result outputs hold their last value and the valid flag is low. A search strobe moves the machine to `S_RESP` (transition *accept*). In `S_RESP` the valid flag is high. The machine stays in `S_RESP` while strobes continue back to back (transition *chain*). It returns to `S_IDLE` on a cycle with no strobe (transition *drain*). The comparison and the priority pick are combinational. The address and control word are registered at the accepting edge.

Top module: `prio_match_mem`

## Requirements
- R1: After reset, `res_valid` is 0, `res_addr` is 0 and `res_ctrl` is 0. Slots 2..127 are all empty, so any search returns address 1.
- R2: A mask bit of 1 makes that key bit don't-care. A mask bit of 0 requires that key bit to equal the stored pattern bit. A rule matches only when every unmasked bit is equal.
- R3: When several rules match, `res_addr` is the highest-numbered matching slot.
- R4: Slot 0 never matches, and writes to address 0 have no effect. `res_addr` is never 0 while `res_valid` is 1.
- R5: Slot 1 always matches. When it wins, `res_ctrl` equals the parameter `DEFAULT_CTRL`.
- R6: Writes to address 1 have no effect. Its pattern, mask and control word stay fixed.
- R7: `res_ctrl` is the control word stored in the winning slot, delivered in the same cycle as `res_addr`.
- R8: `res_valid` is 1 exactly in the cycle after each cycle that has `srch_valid` at a clock edge, including back-to-back searches. Otherwise it is 0.
- R9: A search in the same cycle as a write compares against the table contents from before that write. The written rule is used from the next cycle on.
- R10: In a cycle without a search strobe, `res_addr` and `res_ctrl` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one rule |
| wr_addr | input | 7 | Slot to load |
| wr_data | input | 15 | Rule pattern |
| wr_mask | input | 15 | Rule mask, 1 = don't care |
| wr_ctrl | input | 8 | Rule control word |
| srch_valid | input | 1 | Search strobe |
| srch_key | input | 15 | Search key |
| res_valid | output | 1 | Result valid, one cycle after strobe |
| res_addr | output | 7 | Highest matching slot |
| res_ctrl | output | 8 | Control word of that slot |

## Verification
The bench builds the block with the default geometry of 128 slots, 15-bit keys and 8-bit control words. It sets `DEFAULT_CTRL` to a nonzero value, 8'h3C, so that a default hit can be told apart from an empty or zeroed control word. Keeping the full 128-slot depth lets the tests load the topmost slot, 127, and check that it outranks a catch-all rule lower down. A fully masked rule then covers every key, which lets the tests check that priority picks the higher slot and that the result is taken from the old contents when a write and a search share a cycle.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
    // result-side sequencing
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } pmm_state_e;

    localparam int unsigned PMM_NEVER_SLOT  = 0;
    localparam int unsigned PMM_ALWAYS_SLOT = 1;
endpackage

// File: rtl/pmm_entry_bank.sv
module pmm_entry_bank
    import pmm_pkg::*;
#(
    parameter int unsigned          ENTRIES      = 128,
    parameter int unsigned          DW           = 15,
    parameter int unsigned          CW           = 8,
    parameter logic [CW-1:0]        DEFAULT_CTRL = '0,
    localparam int unsigned         AW           = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic [DW-1:0]                 wr_mask,
    input  logic [CW-1:0]                 wr_ctrl,
    input  logic [DW-1:0]                 key,
    output logic [ENTRIES-1:0]            hit,
    output logic [ENTRIES-1:0][CW-1:0]    ctrl_all
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        if (g == PMM_NEVER_SLOT) begin : g_never
            assign hit[g]      = 1'b0;
            assign ctrl_all[g] = '0;
        end else if (g == PMM_ALWAYS_SLOT) begin : g_always
            assign hit[g]      = 1'b1;
            assign ctrl_all[g] = DEFAULT_CTRL;
        end else begin : g_rule
            logic          vld_q;
            logic [DW-1:0] pat_q;
            logic [DW-1:0] msk_q;
            logic [CW-1:0] ctl_q;
            logic          sel;

            assign sel = wr_en && (wr_addr == AW'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    pat_q <= '0;
                    msk_q <= '0;
                    ctl_q <= '0;
                end else if (sel) begin
                    vld_q <= 1'b1;
                    pat_q <= wr_data;
                    msk_q <= wr_mask;
                    ctl_q <= wr_ctrl;
                end
            end

            assign hit[g]      = vld_q && (((key ^ pat_q) & ~msk_q) == '0);
            assign ctrl_all[g] = ctl_q;
        end
    end
endmodule

// File: rtl/pmm_prio_enc.sv
module pmm_prio_enc #(
    parameter int unsigned  N  = 128,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [AW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/prio_match_mem.sv
module prio_match_mem
    import pmm_pkg::*;
#(
    parameter int unsigned          ENTRIES      = 128,
    parameter int unsigned          DW           = 15,
    parameter int unsigned          CW           = 8,
    parameter logic [CW-1:0]        DEFAULT_CTRL = '0,
    localparam int unsigned         AW           = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] wr_mask,
    input  logic [CW-1:0] wr_ctrl,
    input  logic          srch_valid,
    input  logic [DW-1:0] srch_key,
    output logic          res_valid,
    output logic [AW-1:0] res_addr,
    output logic [CW-1:0] res_ctrl
);
    logic [ENTRIES-1:0]         hit;
    logic [ENTRIES-1:0][CW-1:0] ctrl_all;
    logic [AW-1:0]              win;
    pmm_state_e                 state_q, state_d;

    pmm_entry_bank #(
        .ENTRIES      (ENTRIES),
        .DW           (DW),
        .CW           (CW),
        .DEFAULT_CTRL (DEFAULT_CTRL)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .wr_ctrl  (wr_ctrl),
        .key      (srch_key),
        .hit      (hit),
        .ctrl_all (ctrl_all)
    );

    pmm_prio_enc #(.N(ENTRIES)) u_enc (
        .req (hit),
        .idx (win)
    );

    // next state: accept / chain / drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (srch_valid)  state_d = S_RESP;
            S_RESP: if (!srch_valid) state_d = S_IDLE;
            default:                 state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // registered result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_addr <= '0;
            res_ctrl <= '0;
        end else if (srch_valid) begin
            res_addr <= win;
            res_ctrl <= ctrl_all[win];
        end
    end

    assign res_valid = (state_q == S_RESP);
endmodule

// File: rtl/pmm_chk.sv
module pmm_chk #(
    parameter int unsigned   AW           = 7,
    parameter int unsigned   CW           = 8,
    parameter logic [CW-1:0] DEFAULT_CTRL = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srch_valid,
    input logic          res_valid,
    input logic [AW-1:0] res_addr,
    input logic [CW-1:0] res_ctrl
);
    // R8
    res_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_valid |=> res_valid);

    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid |=> !res_valid);

    // R4
    never_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_addr != '0));

    // R5
    default_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_addr == AW'(1)) |-> (res_ctrl == DEFAULT_CTRL));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_valid |=> ($stable(res_addr) && $stable(res_ctrl)));
endmodule

bind prio_match_mem pmm_chk #(
    .AW           (AW),
    .CW           (CW),
    .DEFAULT_CTRL (DEFAULT_CTRL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_valid (srch_valid),
    .res_valid  (res_valid),
    .res_addr   (res_addr),
    .res_ctrl   (res_ctrl)
);

// File: tb/tb_prio_match_mem.sv
module tb_prio_match_mem;
    localparam int        CLK_PERIOD = 10;
    localparam int        AW  = 7;
    localparam int        DW  = 15;
    localparam int        CW  = 8;
    localparam logic [7:0] DEF = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] wr_mask = '0;
    logic [CW-1:0] wr_ctrl = '0;
    logic          srch_valid = 1'b0;
    logic [DW-1:0] srch_key = '0;
    logic          res_valid;
    logic [AW-1:0] res_addr;
    logic [CW-1:0] res_ctrl;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_match_mem #(.DEFAULT_CTRL(DEF)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .wr_ctrl(wr_ctrl),
        .srch_valid(srch_valid), .srch_key(srch_key),
        .res_valid(res_valid), .res_addr(res_addr), .res_ctrl(res_ctrl)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d, input int m, input int c);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        wr_mask = DW'(m); wr_ctrl = CW'(c);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one search; sampled just after the capturing edge
    task automatic look(input string req, input int key, input int exp_a, input int exp_c);
        @(negedge clk);
        srch_valid = 1'b1; srch_key = DW'(key);
        @(posedge clk); #1;
        check({req, " valid"}, int'(res_valid), 1);
        check({req, " addr"}, int'(res_addr), exp_a);
        check({req, " ctrl"}, int'(res_ctrl), exp_c);
        @(negedge clk);
        srch_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid", int'(res_valid), 0);
        check("R1 addr", int'(res_addr), 0);
        check("R1 ctrl", int'(res_ctrl), 0);
        look("R1 empty table", 15'h1234, 1, DEF);
    endtask

    task automatic t_exact;
        wr(10, 15'h0155, 15'h0000, 8'h11);
        look("R7 exact", 15'h0155, 10, 8'h11);
        look("R2 one bit off", 15'h0154, 1, DEF);
    endtask

    task automatic t_mask;
        wr(20, 15'h7F00, 15'h00FF, 8'h22);
        look("R2 masked low byte", 15'h7F3A, 20, 8'h22);
        look("R2 unmasked bit differs", 15'h7E3A, 1, DEF);
    endtask

    task automatic t_reserved;
        wr(0, 15'h5555, 15'h7FFF, 8'h99);
        look("R4 write to slot 0", 15'h5555, 1, DEF);
        wr(1, 15'h5555, 15'h0000, 8'h88);
        look("R6 write to slot 1", 15'h5555, 1, DEF);
        look("R5 default hit", 15'h0ABC, 1, DEF);
    endtask

    task automatic t_priority;
        wr(30, 15'h0000, 15'h7FFF, 8'h33);
        look("R3 catch-all above 10", 15'h0155, 30, 8'h33);
        wr(127, 15'h0155, 15'h0000, 8'h77);
        look("R3 top slot wins", 15'h0155, 127, 8'h77);
        look("R3 catch-all only", 15'h1111, 30, 8'h33);
    endtask

    task automatic t_timing;
        @(negedge clk);
        srch_valid = 1'b1; srch_key = 15'h0155;
        @(posedge clk); #1;
        check("R8 first of pair valid", int'(res_valid), 1);
        check("R8 first of pair addr", int'(res_addr), 127);
        @(negedge clk);
        srch_key = 15'h1111;
        @(posedge clk); #1;
        check("R8 second of pair valid", int'(res_valid), 1);
        check("R8 second of pair addr", int'(res_addr), 30);
        @(negedge clk);
        srch_valid = 1'b0;
        @(posedge clk); #1;
        check("R8 drops after last", int'(res_valid), 0);
    endtask

    task automatic t_overlap;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd40; wr_data = 15'h2222;
        wr_mask = '0; wr_ctrl = 8'h44;
        srch_valid = 1'b1; srch_key = 15'h2222;
        @(posedge clk); #1;
        check("R9 same-cycle uses old", int'(res_addr), 30);
        @(negedge clk);
        wr_en = 1'b0; srch_valid = 1'b0;
        look("R9 new rule next cycle", 15'h2222, 40, 8'h44);
    endtask

    task automatic t_hold;
        @(negedge clk);
        srch_key = 15'h0155;
        repeat (3) @(posedge clk);
        #1;
        check("R10 addr held", int'(res_addr), 40);
        check("R10 ctrl held", int'(res_ctrl), 8'h44);
        check("R8 idle valid", int'(res_valid), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_exact();
        t_mask();
        t_reserved();
        t_priority();
        t_timing();
        t_overlap();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule